// File: doc/BRIEF.md
# Peak-Current PWM Cycle Sequencer

This block produces the gate-drive pulse of a fixed-frequency, peak-current-mode switching converter. All timing is counted in ticks of the system clock. A period counter starts a pulse at the beginning of every switching cycle. The pulse then ends for one of two reasons: a digitised comparator result reports a trip, or a maximum-duty clamp expires. The comparators cover the regulation loop, the current limit, the soft-start ramp and a short-circuit detector. Their analog front ends, slope compensation and the gate driver sit outside the block, and each arrives here as one bit.

After the drive rises, the comparator results are blanked in two stages. The short-circuit input opens first. The regulation-path inputs open later. When the loop demands very little, a skip input with hysteresis holds off new pulses. Every terminated pulse reports its cause as a one-hot code for one clock. If the short-circuit detector ends several pulses in a row, the block raises a fault request and stops switching until it is disabled.

Top module: `pcm_pulse_sequencer`

## Requirements
- R1: While `enable_i` is high, the drive rises on the clock edge at which the period counter is at zero. The counter wraps every `PERIOD_TICKS` (default 40) clocks. Nothing else starts a pulse.
- R2: If no trip ends a pulse, the drive stays high for exactly `PERIOD_TICKS*DUTY_PCT/100` clocks (default 32) and then falls with cause DMAX.
- R3: The short-circuit input is ignored in the first `SC_BLANK_TICKS` (default 8) clocks of a pulse and while the drive is low.
- R4: The PWM, current-limit and soft-start inputs are ignored in the first `REG_BLANK_TICKS` (default 12) clocks of a pulse and while the drive is low.
- R5: Any unblanked trip ends the pulse on the next edge. `end_valid_o` pulses for one clock while the drive is low for the first time. `end_cause_o` then carries one bit: 0 PWM, 1 current limit, 2 soft start, 3 short circuit, 4 DMAX clamp. Simultaneous causes resolve in the order short circuit, current limit, soft start, PWM, DMAX. Outside that clock it is zero.
- R6: When `comp_low_i` is high, skip mode is entered on the next edge and no new pulse starts. Only a high `comp_resume_i` leaves it. Dropping `comp_low_i` alone does not.
- R7: When `SC_LIMIT` (default 4) consecutive pulses end with cause short circuit, `fault_req_o` rises on the edge where the last one ends. Drive then stays low while the fault is held.
- R8: A pulse that ends with any cause other than short circuit clears the consecutive short-circuit count.
- R9: `enable_i` low forces the drive low on the next edge without reporting a cause. It also clears the period counter, skip mode, the short-circuit count and the fault request.
- R10: Under reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run enable; low idles and clears the block |
| pwm_trip_i | input | 1 | Regulation comparator trip |
| ilim_trip_i | input | 1 | Current-limit comparator trip |
| ss_trip_i | input | 1 | Soft-start comparator trip |
| sc_trip_i | input | 1 | Short-circuit comparator trip |
| comp_low_i | input | 1 | Loop demand below the skip threshold |
| comp_resume_i | input | 1 | Loop demand above threshold plus hysteresis |
| drive_o | output | 1 | Gate-drive request |
| end_valid_o | output | 1 | One-clock strobe after a pulse ends |
| end_cause_o | output | 5 | One-hot termination cause |
| fault_req_o | output | 1 | Short-circuit fault request |

## Verification
The first stimulus has no trips at all, which exposes the period and the duty clamp. A second holds the comparators permanently asserted, so the pulse width shows exactly where each blanking window opens. Trips are then placed only inside the blanking windows to show that they are ignored. Trips at a fixed point of the pulse, alone and in combination, check the cause encoding and its priority. Interleaved short-circuit and other terminations tell counter clearing apart from fault entry. Skip-mode and mid-pulse disable sequences complete the set.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  localparam int CAUSE_W = 5;

  typedef enum int unsigned {
    CZ_PWM  = 0,
    CZ_ILIM = 1,
    CZ_SS   = 2,
    CZ_SC   = 3,
    CZ_DMAX = 4
  } cause_idx_e;

  typedef logic [CAUSE_W-1:0] cause_t;

  function automatic int clamp_ticks(input int period, input int pct);
    return (period * pct) / 100;
  endfunction

endpackage

// File: rtl/pcm_cycle_timer.sv
module pcm_cycle_timer #(
  parameter int PERIOD_TICKS = 40,
  parameter int CW           = $clog2(PERIOD_TICKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  output logic [CW-1:0] cnt_o,
  output logic          cycle_start_o
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)            cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o         = cnt_q;
  assign cycle_start_o = run_i && (cnt_q == '0);

  assert_period_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_q == LAST) |=> (cnt_q == '0));

endmodule

// File: rtl/pcm_term_select.sv
module pcm_term_select
  import pcm_pkg::*;
#(
  parameter int CW         = 6,
  parameter int SC_BLANK   = 8,
  parameter int REG_BLANK  = 12,
  parameter int DMAX_TICKS = 32
) (
  input  logic          drive_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          pwm_i,
  input  logic          ilim_i,
  input  logic          ss_i,
  input  logic          sc_i,
  output cause_t        cause_o,
  output logic          ended_o
);

  localparam logic [CW-1:0] SC_OPEN  = CW'(SC_BLANK);
  localparam logic [CW-1:0] REG_OPEN = CW'(REG_BLANK);
  localparam logic [CW-1:0] CLAMP    = CW'(DMAX_TICKS);

  logic sc_window, reg_window;

  always_comb begin
    // cnt_i counts high clocks: 1 in the first clock after the rise
    sc_window  = drive_i && (cnt_i > SC_OPEN);
    reg_window = drive_i && (cnt_i > REG_OPEN);
    cause_o    = '0;
    if (sc_window && sc_i)              cause_o[CZ_SC]   = 1'b1;
    else if (reg_window && ilim_i)      cause_o[CZ_ILIM] = 1'b1;
    else if (reg_window && ss_i)        cause_o[CZ_SS]   = 1'b1;
    else if (reg_window && pwm_i)       cause_o[CZ_PWM]  = 1'b1;
    else if (drive_i && cnt_i == CLAMP) cause_o[CZ_DMAX] = 1'b1;
    ended_o = |cause_o;
  end

endmodule

// File: rtl/pcm_sc_guard.sv
module pcm_sc_guard #(
  parameter int SC_LIMIT = 4,
  parameter int SCW      = $clog2(SC_LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ended_i,
  input  logic sc_end_i,
  output logic fault_o
);

  localparam logic [SCW-1:0] LIM = SCW'(SC_LIMIT);

  logic [SCW-1:0] run_q, run_d;
  logic           fault_q, fault_d;

  always_comb begin
    run_d   = run_q;
    fault_d = fault_q;
    if (!run_i) begin
      run_d   = '0;
      fault_d = 1'b0;
    end else if (ended_i) begin
      if (!sc_end_i)        run_d = '0;
      else if (run_q != LIM) run_d = run_q + 1'b1;
      if (sc_end_i && (run_q + 1'b1 == LIM)) fault_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      fault_q <= fault_d;
    end
  end

  assign fault_o = fault_q;

  assert_fault_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && fault_q) |=> fault_q);

  assert_clear_on_other_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && ended_i && !sc_end_i && !fault_q) |=> (run_q == '0 && !fault_q));

endmodule

// File: rtl/pcm_pulse_sequencer.sv
module pcm_pulse_sequencer
  import pcm_pkg::*;
#(
  parameter int PERIOD_TICKS    = 40,
  parameter int DUTY_PCT        = 80,
  parameter int SC_BLANK_TICKS  = 8,
  parameter int REG_BLANK_TICKS = 12,
  parameter int SC_LIMIT        = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               pwm_trip_i,
  input  logic               ilim_trip_i,
  input  logic               ss_trip_i,
  input  logic               sc_trip_i,
  input  logic               comp_low_i,
  input  logic               comp_resume_i,
  output logic               drive_o,
  output logic               end_valid_o,
  output logic [CAUSE_W-1:0] end_cause_o,
  output logic               fault_req_o
);

  localparam int CW         = $clog2(PERIOD_TICKS);
  localparam int DMAX_TICKS = clamp_ticks(PERIOD_TICKS, DUTY_PCT);
  localparam logic [CW-1:0] CLAMP = CW'(DMAX_TICKS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  logic [CW-1:0] cnt;
  logic          cycle_start;
  cause_t        cause;
  logic          ended;
  logic          fault;

  pcm_cycle_timer #(.PERIOD_TICKS(PERIOD_TICKS), .CW(CW)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .run_i        (enable_i),
    .cnt_o        (cnt),
    .cycle_start_o(cycle_start)
  );

  logic drive_q, drive_d;
  logic skip_q, skip_d;
  logic valid_q, valid_d;
  cause_t cause_q, cause_d;

  pcm_term_select #(
    .CW(CW), .SC_BLANK(SC_BLANK_TICKS), .REG_BLANK(REG_BLANK_TICKS),
    .DMAX_TICKS(DMAX_TICKS)
  ) u_term (
    .drive_i(drive_q),
    .cnt_i  (cnt),
    .pwm_i  (pwm_trip_i),
    .ilim_i (ilim_trip_i),
    .ss_i   (ss_trip_i),
    .sc_i   (sc_trip_i),
    .cause_o(cause),
    .ended_o(ended)
  );

  pcm_sc_guard #(.SC_LIMIT(SC_LIMIT)) u_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .run_i   (enable_i),
    .ended_i (ended),
    .sc_end_i(cause[CZ_SC]),
    .fault_o (fault)
  );

  always_comb begin
    drive_d = drive_q;
    skip_d  = skip_q;
    valid_d = 1'b0;
    cause_d = '0;
    if (!enable_i) begin
      drive_d = 1'b0;
      skip_d  = 1'b0;
    end else begin
      if (comp_low_i)         skip_d = 1'b1;
      else if (comp_resume_i) skip_d = 1'b0;
      if (cycle_start && !skip_q && !fault) begin
        drive_d = 1'b1;
      end else if (ended) begin
        drive_d = 1'b0;
        valid_d = 1'b1;
        cause_d = cause;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      skip_q  <= 1'b0;
      valid_q <= 1'b0;
      cause_q <= '0;
    end else begin
      drive_q <= drive_d;
      skip_q  <= skip_d;
      valid_q <= valid_d;
      cause_q <= cause_d;
    end
  end

  assign drive_o     = drive_q;
  assign end_valid_o = valid_q;
  assign end_cause_o = cause_q;
  assign fault_req_o = fault;

  assert_rise_at_start_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(drive_q) |-> $past(cnt == '0));

  assert_clamp_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (drive_q && cnt == CLAMP) |=> !drive_q);

  assert_cause_with_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    valid_q |-> ($fell(drive_q) && $countones(cause_q) == 1));

  assert_skip_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (skip_q && !drive_q) |=> !drive_q);

  assert_fault_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    fault |-> !drive_q);

  assert_disable_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    !enable_i |=> (!drive_q && !valid_q));

endmodule

// File: tb/pcm_pulse_sequencer_tb.sv
module pcm_pulse_sequencer_tb_top;

  localparam int P    = 40;
  localparam int DMAX = 32;
  localparam int BSC  = 8;
  localparam int BREG = 12;
  localparam int LIM  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic en, pwm, ilim, ss, sc, clow, cres;
  logic drive, valid, fault;
  logic [4:0] cause;

  always #4 clk = ~clk;

  pcm_pulse_sequencer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en),
    .pwm_trip_i(pwm), .ilim_trip_i(ilim), .ss_trip_i(ss), .sc_trip_i(sc),
    .comp_low_i(clow), .comp_resume_i(cres),
    .drive_o(drive), .end_valid_o(valid), .end_cause_o(cause), .fault_req_o(fault)
  );

  int vectors = 0;
  int misses  = 0;
  string tag = "R10";

  // behavioural reference state
  int m_cnt = 0, m_scn = 0;
  bit m_drive = 0, m_skip = 0, m_fault = 0, m_valid = 0;
  bit [4:0] m_cause = '0;

  task automatic check(input string req, input bit [7:0] act, input bit [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%b expected=%b (drive,valid,cause,fault) t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit [4:0] c;
    bit ended;
    int n_cnt, n_scn;
    bit n_drive, n_skip, n_fault;
    c = '0;
    if (!en) begin
      n_cnt = 0; n_scn = 0; n_drive = 0; n_skip = 0; n_fault = 0;
      m_valid = 0; m_cause = '0;
    end else begin
      if (m_drive) begin
        if (sc && m_cnt > BSC)         c = 5'b01000;
        else if (ilim && m_cnt > BREG) c = 5'b00010;
        else if (ss && m_cnt > BREG)   c = 5'b00100;
        else if (pwm && m_cnt > BREG)  c = 5'b00001;
        else if (m_cnt == DMAX)        c = 5'b10000;
      end
      ended = (c != 0);
      n_scn = m_scn; n_fault = m_fault;
      if (ended) begin
        if (c == 5'b01000) n_scn = (m_scn < LIM) ? m_scn + 1 : LIM;
        else n_scn = 0;
        if (n_scn == LIM) n_fault = 1;
      end
      n_skip = clow ? 1'b1 : (cres ? 1'b0 : m_skip);
      n_drive = m_drive;
      m_valid = 0; m_cause = '0;
      if (m_cnt == 0 && !m_skip && !m_fault) n_drive = 1;
      else if (ended) begin n_drive = 0; m_valid = 1; m_cause = c; end
      n_cnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
    end
    m_cnt = n_cnt; m_scn = n_scn; m_drive = n_drive; m_skip = n_skip; m_fault = n_fault;
    @(negedge clk);
    check(tag, {drive, valid, cause, fault}, {m_drive, m_valid, m_cause, m_fault});
  endtask

  task automatic clear_trips();
    pwm = 0; ilim = 0; ss = 0; sc = 0; clow = 0; cres = 0;
  endtask

  int highs;

  initial begin
    rst_n = 0; en = 0; clear_trips();
    repeat (3) @(negedge clk);
    // R10: outputs low while in reset
    check("R10", {drive, valid, cause, fault}, 8'd0);
    rst_n = 1;
    tag = "R10";
    repeat (4) tick();

    // R1: free-running cycles, pulses start at counter zero
    en = 1; tag = "R1";
    repeat (P) tick();
    // R2: no trips, duty clamp ends every pulse
    tag = "R2"; highs = 0;
    for (int i = 0; i < P; i++) begin tick(); if (drive) highs++; end
    check("R2", 8'(highs), 8'(DMAX));

    // R4: regulation trip held high, opens after its blanking window
    tag = "R4"; pwm = 1;
    repeat (2 * P) tick();
    pwm = 0;
    for (int i = 0; i < 2 * P; i++) begin
      ilim = (m_cnt >= 1 && m_cnt <= BREG);
      ss   = (m_cnt >= 1 && m_cnt <= BREG);
      tick();
    end
    clear_trips();

    // R3: short-circuit trips only inside its blanking window are ignored
    tag = "R3";
    for (int i = 0; i < 2 * P; i++) begin sc = (m_cnt >= 1 && m_cnt <= BSC); tick(); end
    sc = 1; tick(); tick(); sc = 0;   // drive low: ignored
    for (int i = 0; i < P; i++) tick();

    // R5: cause encoding and priority at a fixed point of the pulse
    tag = "R5";
    for (int i = 0; i < P; i++) begin pwm = (m_cnt == 20); sc = (m_cnt == 20); tick(); end
    for (int i = 0; i < P; i++) begin pwm = (m_cnt == 20); ilim = (m_cnt == 20); ss = (m_cnt == 20); sc = 0; tick(); end
    for (int i = 0; i < P; i++) begin ilim = 0; pwm = (m_cnt == 20); ss = (m_cnt == 20); tick(); end
    for (int i = 0; i < P; i++) begin ss = 0; pwm = (m_cnt == 20); tick(); end
    clear_trips();

    // R8: three short-circuit ends, one other end, repeat: never a fault
    tag = "R8";
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 3 * P; i++) begin sc = (m_cnt == 15); tick(); end
      sc = 0;
      for (int i = 0; i < P; i++) begin ilim = (m_cnt == 15); tick(); end
      ilim = 0;
    end
    check("R8", {7'd0, fault}, 8'd0);

    // R6: skip entry, low released without resume, then resume
    tag = "R6"; clow = 1; tick(); clow = 0;
    highs = 0;
    for (int i = 0; i < 2 * P; i++) begin tick(); if (drive) highs++; end
    cres = 1; tick(); cres = 0;
    for (int i = 0; i < 2 * P; i++) tick();

    // R7: short-circuit on every pulse leads to a fault
    tag = "R7"; sc = 1;
    repeat (6 * P) tick();
    check("R7", {drive, 6'd0, fault}, 8'b0000_0001);
    sc = 0;

    // R9: disable clears fault; disable mid-pulse drops drive with no cause
    tag = "R9"; en = 0; tick(); tick();
    check("R9", {7'd0, fault}, 8'd0);
    en = 1;
    for (int i = 0; i < 5; i++) tick();
    en = 0; tick();
    check("R9", {drive, valid, 6'd0}, 8'd0);
    en = 1;
    repeat (P) tick();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #800000;
    misses++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule